// File: doc/BRIEF.md
# General-Purpose Port Register Bank

This block holds the software-visible state of a 16-pin general-purpose port. It keeps the pin data word, two interrupt mask words (A and B) and five configuration words: direction, polarity, edge select, both-edge select and input enable. The data word and each mask word can be reached through four addresses. One address replaces the word. The other three clear, set or toggle the bits written as 1, and all three read back the current word. The configuration words have a single plain address each.

Software reaches the bank over a simple single-cycle bus. A request carries a write flag, a byte address, an access size and 16-bit write data. Read data and an error code come back in the next cycle and last for one cycle. Pin sampling and interrupt detection belong to a neighbouring block. That block sends input-driven data updates in, and it supplies the per-pin interrupt state, which this bank reduces through each mask into the two interrupt lines. The bank drives the pin output values, the output enables and a one-cycle change pulse for output pins. It also exposes the configuration words.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register is zero, so all pins are disabled inputs. bus_rdata, bus_err, pin_out, pin_oe, out_chg, irq_a, irq_b and all cfg_* outputs are 0.
- R2: A legal write to a plain address replaces the whole word. Register index = byte address / 4, in this order: 0 data, 1 data-clear, 2 data-set, 3 data-toggle, 4 mask A, 5 mask A-clear, 6 mask A-set, 7 mask A-toggle, 8 mask B, 9 mask B-clear, 10 mask B-set, 11 mask B-toggle, 12 direction, 13 polarity, 14 edge, 15 both-edge, 16 input enable.
- R3: A write to a clear alias clears, in its base word, each bit written as 1.
- R4: A write to a set alias ORs the written value into its base word.
- R5: A write to a toggle alias XORs the written value into its base word.
- R6: A read of any clear, set or toggle alias returns the current value of its base word.
- R7: bus_size encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved, and only 1 is legal. Any other size gives bus_err = 1 (size error), even at an unmapped address, and changes no state.
- R8: An address with bits [1:0] not zero, or with index 17 or above, gives bus_err = 2 (unmapped) and changes no state.
- R9: bus_rdata and bus_err are valid in the cycle after the request and last for one cycle. At all other times, and for writes and errored accesses, they are 0. A bus_err of 0 means success.
- R10: pin_oe equals the direction word and pin_out equals the data word.
- R11: In the cycle after a legal write to the data group or to direction, out_chg = new direction AND (new data XOR old data). At all other times out_chg is 0.
- R12: irq_a (irq_b) is the OR of irq_state AND mask A (mask B), registered. A change of a mask or of irq_state shows one cycle later.
- R13: pin_upd_en/pin_upd_val load a data bit only where direction is 0 and input enable is 1. Elsewhere the update is ignored.
- R14: A bus write to the data group in the same cycle as a pin update wins on the bits it touches: all bits for a plain write, and only the bits written as 1 for an alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, valid the cycle after a read |
| bus_err | output | 2 | Response code: 0 ok, 1 size, 2 unmapped |
| pin_upd_en | input | WIDTH | Per-bit input-driven data update strobe |
| pin_upd_val | input | WIDTH | Sampled pin levels for the update |
| irq_state | input | WIDTH | Per-pin interrupt state from the detector |
| pin_out | output | WIDTH | Output pin values |
| pin_oe | output | WIDTH | Output enables |
| out_chg | output | WIDTH | One-cycle pulse on output pins whose value changed |
| cfg_dir | output | WIDTH | Direction word |
| cfg_polar | output | WIDTH | Polarity word |
| cfg_edge | output | WIDTH | Edge-select word |
| cfg_both | output | WIDTH | Both-edge word |
| cfg_inen | output | WIDTH | Input-enable word |
| irq_a | output | 1 | Interrupt line through mask A |
| irq_b | output | 1 | Interrupt line through mask B |

## Verification
The bench first targets the alias readback: a decoder that lets aliases read as zero, or that writes through the wrong offset, returns the wrong word. It then checks the error ordering. An illegal size at an unmapped address must report a size error, and an errored write to a toggle alias must leave the mask unchanged; a bank that ordered the checks the other way would report unmapped, and one without the guard would corrupt state. It also drives a pin update in the same cycle as clear and plain writes, so a design that let the pin win, or let an alias claim all bits, shows the wrong data. Finally, it times the out_chg pulse and the mask-driven interrupt lines cycle by cycle, which exposes any extra or missing register stage.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int NUM_GRP   = 3;               // data, mask A, mask B
   localparam int NUM_CFG   = 5;               // dir, polar, edge, both, inen
   localparam int FIRST_CFG = NUM_GRP * 4;     // index of first config word
   localparam int NUM_REGS  = FIRST_CFG + NUM_CFG;

   localparam int GRP_DATA = 0;
   localparam int GRP_MA   = 1;
   localparam int GRP_MB   = 2;

   localparam int CFG_DIR   = 0;
   localparam int CFG_POLAR = 1;
   localparam int CFG_EDGE  = 2;
   localparam int CFG_BOTH  = 3;
   localparam int CFG_INEN  = 4;

   localparam logic [1:0] SIZE_HALF = 2'd1;

   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_CLR   = 2'd1,
      OP_SET   = 2'd2,
      OP_TGL   = 2'd3
   } alias_op_e;

   typedef enum logic [1:0] {
      ERR_NONE  = 2'd0,
      ERR_SIZE  = 2'd1,
      ERR_UNMAP = 2'd2
   } resp_err_e;

endpackage

// File: rtl/gpio_bank_dec.sv
module gpio_bank_dec
   import gpio_bank_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int STRIDE_LG2 = 2,
   localparam int IDX_W     = ADDR_W - STRIDE_LG2
) (
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output resp_err_e         err_code,
   output logic              acc_ok,
   output logic [NUM_GRP-1:0] grp_we,
   output logic [NUM_CFG-1:0] cfg_we,
   output alias_op_e         op,
   output logic [IDX_W-1:0]  sel_idx
);

   logic aligned;
   logic mapped;
   int   idx_i;

   assign sel_idx = addr[ADDR_W-1:STRIDE_LG2];
   assign aligned = (addr[STRIDE_LG2-1:0] == '0);
   assign idx_i   = int'(sel_idx);
   assign mapped  = aligned && (idx_i < NUM_REGS);

   // size check is taken first, then the map check
   always_comb begin
      err_code = ERR_NONE;
      acc_ok   = 1'b0;
      if (req) begin
         if (size != SIZE_HALF) begin
            err_code = ERR_SIZE;
         end else if (!mapped) begin
            err_code = ERR_UNMAP;
         end else begin
            acc_ok = 1'b1;
         end
      end
   end

   always_comb begin
      grp_we = '0;
      cfg_we = '0;
      op     = OP_WRITE;
      if (idx_i < FIRST_CFG) begin
         op = alias_op_e'(sel_idx[1:0]);
      end
      for (int g = 0; g < NUM_GRP; g++) begin
         grp_we[g] = acc_ok && wr && (idx_i < FIRST_CFG) && ((idx_i >> 2) == g);
      end
      for (int c = 0; c < NUM_CFG; c++) begin
         cfg_we[c] = acc_ok && wr && (idx_i == FIRST_CFG + c);
      end
   end

endmodule

// File: rtl/gpio_bank_areg.sv
module gpio_bank_areg
   import gpio_bank_pkg::*;
#(
   parameter int WIDTH     = 16,
   parameter bit EXT_MERGE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  alias_op_e        op,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] ext_en,
   input  logic [WIDTH-1:0] ext_val,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] nxt
);

   logic [WIDTH-1:0] bus_res;
   logic [WIDTH-1:0] touch;
   logic [WIDTH-1:0] base;

   always_comb begin
      unique case (op)
         OP_CLR: begin
            bus_res = q & ~wdata;
            touch   = wdata;
         end
         OP_SET: begin
            bus_res = q | wdata;
            touch   = wdata;
         end
         OP_TGL: begin
            bus_res = q ^ wdata;
            touch   = wdata;
         end
         default: begin
            bus_res = wdata;
            touch   = '1;
         end
      endcase
   end

   generate
      if (EXT_MERGE) begin : g_merge
         assign base = (q & ~ext_en) | (ext_val & ext_en);
      end else begin : g_plain
         logic unused_ext;
         assign unused_ext = ^{ext_en, ext_val};
         assign base       = q;
      end
   endgenerate

   // bus-touched bits take the bus result, the rest keep base
   assign nxt = we ? ((bus_res & touch) | (base & ~touch)) : base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

endmodule

// File: rtl/gpio_bank_rmux.sv
module gpio_bank_rmux
   import gpio_bank_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int IDX_W = 6
) (
   input  logic [IDX_W-1:0]              sel_idx,
   input  logic [NUM_GRP-1:0][WIDTH-1:0] grp_val,
   input  logic [NUM_CFG-1:0][WIDTH-1:0] cfg_val,
   output logic [WIDTH-1:0]              rd_val
);

   int idx_i;
   assign idx_i = int'(sel_idx);

   always_comb begin
      rd_val = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if ((idx_i < FIRST_CFG) && ((idx_i >> 2) == g)) rd_val = grp_val[g];
      end
      for (int c = 0; c < NUM_CFG; c++) begin
         if (idx_i == FIRST_CFG + c) rd_val = cfg_val[c];
      end
   end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter int ADDR_W     = 8,
   parameter int STRIDE_LG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   output logic [1:0]        bus_err,
   input  logic [WIDTH-1:0]  pin_upd_en,
   input  logic [WIDTH-1:0]  pin_upd_val,
   input  logic [WIDTH-1:0]  irq_state,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  out_chg,
   output logic [WIDTH-1:0]  cfg_dir,
   output logic [WIDTH-1:0]  cfg_polar,
   output logic [WIDTH-1:0]  cfg_edge,
   output logic [WIDTH-1:0]  cfg_both,
   output logic [WIDTH-1:0]  cfg_inen,
   output logic              irq_a,
   output logic              irq_b
);

   localparam int IDX_W = ADDR_W - STRIDE_LG2;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("gpio_bank: WIDTH must be at least 1");
      end
      if (STRIDE_LG2 < 1) begin : g_bad_stride
         $error("gpio_bank: STRIDE_LG2 must be at least 1");
      end
      if (IDX_W < $clog2(NUM_REGS)) begin : g_bad_addr
         $error("gpio_bank: ADDR_W too narrow for the register count");
      end
   endgenerate

   resp_err_e                  err_code;
   logic                       acc_ok;
   logic [NUM_GRP-1:0]         grp_we;
   logic [NUM_CFG-1:0]         cfg_we;
   alias_op_e                  op;
   logic [IDX_W-1:0]           sel_idx;
   logic [NUM_GRP-1:0][WIDTH-1:0] grp_q, grp_nxt;
   logic [NUM_CFG-1:0][WIDTH-1:0] cfg_q, cfg_nxt;
   logic [WIDTH-1:0]           rd_val;
   logic [WIDTH-1:0]           data_ext_en;

   gpio_bank_dec #(
      .ADDR_W     (ADDR_W),
      .STRIDE_LG2 (STRIDE_LG2)
   ) i_dec (
      .req      (bus_req),
      .wr       (bus_wr),
      .addr     (bus_addr),
      .size     (bus_size),
      .err_code (err_code),
      .acc_ok   (acc_ok),
      .grp_we   (grp_we),
      .cfg_we   (cfg_we),
      .op       (op),
      .sel_idx  (sel_idx)
   );

   // pin updates land only on enabled inputs
   assign data_ext_en = pin_upd_en & ~cfg_q[CFG_DIR] & cfg_q[CFG_INEN];

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         gpio_bank_areg #(
            .WIDTH     (WIDTH),
            .EXT_MERGE (g == GRP_DATA)
         ) i_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (grp_we[g]),
            .op      (op),
            .wdata   (bus_wdata),
            .ext_en  ((g == GRP_DATA) ? data_ext_en : '0),
            .ext_val (pin_upd_val),
            .q       (grp_q[g]),
            .nxt     (grp_nxt[g])
         );
      end
      for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
         gpio_bank_areg #(
            .WIDTH     (WIDTH),
            .EXT_MERGE (1'b0)
         ) i_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (cfg_we[c]),
            .op      (OP_WRITE),
            .wdata   (bus_wdata),
            .ext_en  ('0),
            .ext_val ('0),
            .q       (cfg_q[c]),
            .nxt     (cfg_nxt[c])
         );
      end
   endgenerate

   gpio_bank_rmux #(
      .WIDTH (WIDTH),
      .IDX_W (IDX_W)
   ) i_rmux (
      .sel_idx (sel_idx),
      .grp_val (grp_q),
      .cfg_val (cfg_q),
      .rd_val  (rd_val)
   );

   // response stage, one cycle after the request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= ERR_NONE;
      end else begin
         bus_rdata <= (acc_ok && !bus_wr) ? rd_val : '0;
         bus_err   <= err_code;
      end
   end

   // output-change pulse and masked interrupt lines
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_chg <= '0;
         irq_a   <= 1'b0;
         irq_b   <= 1'b0;
      end else begin
         if (grp_we[GRP_DATA] || cfg_we[CFG_DIR]) begin
            out_chg <= cfg_nxt[CFG_DIR] & (grp_nxt[GRP_DATA] ^ grp_q[GRP_DATA]);
         end else begin
            out_chg <= '0;
         end
         irq_a <= |(irq_state & grp_q[GRP_MA]);
         irq_b <= |(irq_state & grp_q[GRP_MB]);
      end
   end

   logic [NUM_GRP-1:0][WIDTH-1:0] unused_nxt;
   assign unused_nxt = {grp_nxt[GRP_MB], grp_nxt[GRP_MA], {WIDTH{1'b0}}};

   assign pin_out   = grp_q[GRP_DATA];
   assign pin_oe    = cfg_q[CFG_DIR];
   assign cfg_dir   = cfg_q[CFG_DIR];
   assign cfg_polar = cfg_q[CFG_POLAR];
   assign cfg_edge  = cfg_q[CFG_EDGE];
   assign cfg_both  = cfg_q[CFG_BOTH];
   assign cfg_inen  = cfg_q[CFG_INEN];

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter int ADDR_W     = 8,
   parameter int STRIDE_LG2 = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_size,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [1:0]        bus_err,
   input logic [WIDTH-1:0]  irq_state,
   input logic [WIDTH-1:0]  pin_oe,
   input logic [WIDTH-1:0]  out_chg,
   input logic [WIDTH-1:0]  cfg_dir,
   input logic              irq_a,
   input logic [WIDTH-1:0]  mask_a,
   input logic [WIDTH-1:0]  mask_b
);

   localparam logic [ADDR_W-1:0] MA_SET_ADDR = ADDR_W'(6 << STRIDE_LG2);

   logic bad_map;
   assign bad_map = (bus_addr[STRIDE_LG2-1:0] != '0) ||
                    (int'(bus_addr >> STRIDE_LG2) >= NUM_REGS);

   // R7
   size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && (bus_size != SIZE_HALF) |=> bus_err == ERR_SIZE);

   // R8
   unmap_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && (bus_size == SIZE_HALF) && bad_map |=>
         (bus_err == ERR_UNMAP) && $stable(cfg_dir) && $stable(mask_a) && $stable(mask_b));

   // R9
   idle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |=> (bus_rdata == '0) && (bus_err == ERR_NONE));

   // R4
   maska_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_wr && (bus_size == SIZE_HALF) && (bus_addr == MA_SET_ADDR) |=>
         mask_a == ($past(mask_a) | $past(bus_wdata)));

   // R11
   out_chg_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_chg & ~pin_oe) == '0);

   // R12
   irq_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_a == (|($past(irq_state) & $past(mask_a))));

endmodule

bind gpio_bank gpio_bank_chk #(
   .WIDTH      (WIDTH),
   .ADDR_W     (ADDR_W),
   .STRIDE_LG2 (STRIDE_LG2)
) i_gpio_bank_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_size  (bus_size),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .bus_err   (bus_err),
   .irq_state (irq_state),
   .pin_oe    (pin_oe),
   .out_chg   (out_chg),
   .cfg_dir   (cfg_dir),
   .irq_a     (irq_a),
   .mask_a    (grp_q[1]),
   .mask_b    (grp_q[2])
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [1:0]  bus_size = 2'd1;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [1:0]  bus_err;
   logic [15:0] pin_upd_en = '0;
   logic [15:0] pin_upd_val = '0;
   logic [15:0] irq_state = '0;
   logic [15:0] pin_out, pin_oe, out_chg;
   logic [15:0] cfg_dir, cfg_polar, cfg_edge, cfg_both, cfg_inen;
   logic        irq_a, irq_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_bank i_gpio_bank (
      .clk, .rst_n, .bus_req, .bus_wr, .bus_addr, .bus_size, .bus_wdata,
      .bus_rdata, .bus_err, .pin_upd_en, .pin_upd_val, .irq_state,
      .pin_out, .pin_oe, .out_chg, .cfg_dir, .cfg_polar, .cfg_edge,
      .cfg_both, .cfg_inen, .irq_a, .irq_b
   );

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [1:0]  size;
      logic [15:0] wdata;
      logic [15:0] exp_rd;
      logic [1:0]  exp_err;
      logic [7:0]  rq;
   } vec_t;

   localparam int NVEC = 27;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 8'h00, 2'd1, 16'hA5A5, 16'h0000, 2'd0, 8'd2},  // R2 data
      '{1'b0, 8'h00, 2'd1, 16'h0000, 16'hA5A5, 2'd0, 8'd2},
      '{1'b1, 8'h04, 2'd1, 16'h00FF, 16'h0000, 2'd0, 8'd3},  // R3
      '{1'b0, 8'h08, 2'd1, 16'h0000, 16'hA500, 2'd0, 8'd6},  // R6 set alias read
      '{1'b1, 8'h08, 2'd1, 16'h000F, 16'h0000, 2'd0, 8'd4},  // R4
      '{1'b0, 8'h04, 2'd1, 16'h0000, 16'hA50F, 2'd0, 8'd6},
      '{1'b1, 8'h0C, 2'd1, 16'hFFFF, 16'h0000, 2'd0, 8'd5},  // R5
      '{1'b0, 8'h0C, 2'd1, 16'h0000, 16'h5AF0, 2'd0, 8'd5},
      '{1'b1, 8'h10, 2'd1, 16'h1234, 16'h0000, 2'd0, 8'd2},
      '{1'b1, 8'h18, 2'd1, 16'h0001, 16'h0000, 2'd0, 8'd4},
      '{1'b0, 8'h14, 2'd1, 16'h0000, 16'h1235, 2'd0, 8'd6},
      '{1'b1, 8'h2C, 2'd1, 16'h00F0, 16'h0000, 2'd0, 8'd5},
      '{1'b0, 8'h20, 2'd1, 16'h0000, 16'h00F0, 2'd0, 8'd6},
      '{1'b1, 8'h34, 2'd1, 16'hBEEF, 16'h0000, 2'd0, 8'd2},
      '{1'b0, 8'h34, 2'd1, 16'h0000, 16'hBEEF, 2'd0, 8'd2},
      '{1'b1, 8'h3C, 2'd1, 16'h0102, 16'h0000, 2'd0, 8'd2},
      '{1'b0, 8'h3C, 2'd1, 16'h0000, 16'h0102, 2'd0, 8'd2},
      '{1'b1, 8'h40, 2'd1, 16'h00FF, 16'h0000, 2'd0, 8'd2},
      '{1'b0, 8'h40, 2'd1, 16'h0000, 16'h00FF, 2'd0, 8'd2},
      '{1'b0, 8'h44, 2'd1, 16'h0000, 16'h0000, 2'd2, 8'd8},  // R8 beyond map
      '{1'b0, 8'h00, 2'd0, 16'h0000, 16'h0000, 2'd1, 8'd7},  // R7 byte read
      '{1'b1, 8'h44, 2'd2, 16'h5555, 16'h0000, 2'd1, 8'd7},  // R7 size wins
      '{1'b1, 8'h02, 2'd1, 16'hFFFF, 16'h0000, 2'd2, 8'd8},  // R8 misaligned
      '{1'b1, 8'h1C, 2'd3, 16'hFFFF, 16'h0000, 2'd1, 8'd7},  // R7 no toggle
      '{1'b0, 8'h00, 2'd1, 16'h0000, 16'h5AF0, 2'd0, 8'd8},
      '{1'b0, 8'h10, 2'd1, 16'h0000, 16'h1235, 2'd0, 8'd7},
      '{1'b0, 8'h38, 2'd1, 16'h0000, 16'h0000, 2'd0, 8'd1}   // R1 untouched
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // drive one access; returns at the negedge after the response edge
   task automatic bus_op(input logic w, input logic [7:0] a, input logic [1:0] s,
                         input logic [15:0] d);
      @(negedge clk);
      bus_req   = 1'b1;
      bus_wr    = w;
      bus_addr  = a;
      bus_size  = s;
      bus_wdata = d;
      @(negedge clk);
      bus_req   = 1'b0;
      bus_wr    = 1'b0;
      bus_wdata = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rdata", bus_rdata, 0);
      chk("R1 err", bus_err, 0);
      chk("R1 pin_oe", pin_oe, 0);
      chk("R1 pin_out", pin_out, 0);
      chk("R1 cfg", {cfg_polar, cfg_inen}, 0);
      chk("R1 irq", {irq_a, irq_b, out_chg}, 0);

      for (int i = 0; i < NVEC; i++) begin
         bus_op(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata);
         chk($sformatf("R%0d vec%0d rdata", VECS[i].rq, i), bus_rdata, VECS[i].exp_rd);
         chk($sformatf("R%0d vec%0d err", VECS[i].rq, i), bus_err, VECS[i].exp_err);
      end

      // R9 response lasts one cycle
      bus_op(1'b0, 8'h34, 2'd1, 16'h0);
      chk("R9 read valid", bus_rdata, 16'hBEEF);
      @(negedge clk);
      chk("R9 read gone", bus_rdata, 16'h0000);
      chk("R2 polar port", cfg_polar, 16'hBEEF);

      // R10 / R11 direction write, data unchanged
      bus_op(1'b1, 8'h30, 2'd1, 16'h00FF);
      chk("R10 pin_oe", pin_oe, 16'h00FF);
      chk("R10 pin_out", pin_out, 16'h5AF0);
      chk("R11 dir write no change", out_chg, 16'h0000);
      bus_op(1'b1, 8'h0C, 2'd1, 16'h0101);
      chk("R11 toggle pulse", out_chg, 16'h0001);
      @(negedge clk);
      chk("R11 pulse one cycle", out_chg, 16'h0000);

      // R13 updates on outputs / disabled inputs ignored
      pin_upd_en  = 16'hFFFF;
      pin_upd_val = 16'h0000;
      @(negedge clk);
      pin_upd_en  = '0;
      chk("R13 ignored", pin_out, 16'h5BF1);
      bus_op(1'b1, 8'h40, 2'd1, 16'hFF00);
      pin_upd_en  = 16'hFFFF;
      pin_upd_val = 16'h0000;
      @(negedge clk);
      pin_upd_en  = '0;
      chk("R13 enabled inputs load", pin_out, 16'h00F1);

      // R14 clear alias vs pin update
      pin_upd_en  = 16'hFF00;
      pin_upd_val = 16'hFF00;
      bus_op(1'b1, 8'h04, 2'd1, 16'h0100);
      pin_upd_en  = '0;
      chk("R14 alias touches only ones", pin_out, 16'hFEF1);
      pin_upd_en  = 16'hFF00;
      pin_upd_val = 16'hFF00;
      bus_op(1'b1, 8'h00, 2'd1, 16'h1234);
      pin_upd_en  = '0;
      chk("R14 plain write wins", pin_out, 16'h1234);
      chk("R11 plain write pulse", out_chg, 16'h00C5);

      // R12 interrupt lines
      irq_state = 16'h0001;
      @(negedge clk);
      chk("R12 irq_a set", irq_a, 1'b1);
      chk("R12 irq_b clear", irq_b, 1'b0);
      bus_op(1'b1, 8'h14, 2'd1, 16'h0001);
      chk("R12 irq_a one cycle late", irq_a, 1'b1);
      @(negedge clk);
      chk("R12 irq_a after mask clear", irq_a, 1'b0);
      irq_state = 16'h0080;
      @(negedge clk);
      chk("R12 irq_b set", irq_b, 1'b1);
      irq_state = 16'h0000;
      @(negedge clk);
      chk("R12 irq_b drop", irq_b, 1'b0);

      finish_run();
   end

endmodule